// File: doc/BRIEF.md
# Clock Source Switch with Failure Detection

This block picks the system clock from three oscillators: a multi-speed internal RC, a 16 MHz internal RC and a high-speed external crystal. The selection follows the wake context (system reset, exit from standby, wake from stop) and a software select write. Every change of source goes through a per-source enable handshake, so the output clock never carries a runt pulse.

A monitor in the reference-clock domain counts edges of the external clock in fixed windows. When it sees too few edges, it takes the external clock away at once. It then moves the selection to the 16 MHz RC, sends a one-cycle non-maskable interrupt pulse and holds a break line toward the timers. The failure flag is readable and stays set until software clears it. While the flag is set, requests for the external source are refused.

Top module: `clksw_top`

## Requirements
- R1: After reset, `active_src` reads 0 (multi-speed RC), `fail_flag`, `nmi` and `timer_break` are low, and `clk_sys` runs at the multi-speed RC rate.
- R2: A pulse on `wake_standby` selects the 16 MHz RC (code 1).
- R3: A pulse on `wake_stop` selects the 16 MHz RC when `stop_wake_rc16` is 1, and the multi-speed RC (code 0) when it is 0.
- R4: A `sel_we` pulse writes `sel_wdata`: 0 selects the multi-speed RC, 1 the 16 MHz RC, 2 the external clock. Code 3 is ignored and the running source stays.
- R5: `active_src` gives the code of the source that actually drives `clk_sys`. It changes only after the handshake has completed, so it still shows the old code in the cycle after a write.
- R6: No high or low phase of `clk_sys` after reset is shorter than the shortest half period among the sources.
- R7: With `mon_en` high, a 64-cycle reference window that contains fewer than 4 edges of the external clock sets `fail_flag`. A running external clock never sets it, and with `mon_en` low the flag is never set.
- R8: When the flag sets, `nmi` pulses for exactly one reference cycle and `timer_break` goes high and stays high while the flag is set. The output moves to the 16 MHz RC (code 1).
- R9: While `fail_flag` is set, a write of code 2 is ignored. A `fail_clr` pulse clears the flag and `timer_break`, after which code 2 is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for control and monitor |
| rst | input | 1 | Synchronous active-high reset |
| clk_multi | input | 1 | Multi-speed internal RC clock |
| clk_rc16 | input | 1 | 16 MHz internal RC clock |
| clk_xtal | input | 1 | High-speed external clock |
| wake_standby | input | 1 | Pulse: exit from standby |
| wake_stop | input | 1 | Pulse: wake from stop |
| stop_wake_rc16 | input | 1 | Stop-wake choice: 1 = 16 MHz RC, 0 = multi-speed RC |
| sel_we | input | 1 | Software select write strobe |
| sel_wdata | input | 2 | Software source code |
| mon_en | input | 1 | Enable for the external clock monitor |
| fail_clr | input | 1 | Pulse: clear the failure flag |
| clk_sys | output | 1 | Glitch-free system clock |
| active_src | output | 2 | Code of the source now driving clk_sys |
| fail_flag | output | 1 | Sticky external clock failure flag |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |
| timer_break | output | 1 | Break line toward timers |

## Verification
The bench stops the external clock while it is the running source. If the design waited for the dead clock to finish its handshake, `clk_sys` would stay frozen and never reach the 16 MHz RC. It also counts the NMI pulses across several failing windows, so a design that re-raised the interrupt every window would be caught. A runt-pulse monitor measures every phase of `clk_sys` across all switches, which exposes a mux that switches without the gating sequence. It also checks that `active_src` lags the write, that code 3 and a refused code 2 leave the running clock alone, and that a disabled monitor never trips.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_MULTI = 2'd0,
        SRC_RC16  = 2'd1,
        SRC_XTAL  = 2'd2
    } src_e;

    // one-hot gate pattern expected for a settled selection
    function automatic logic [NSRC-1:0] src_mask(input src_e s);
        logic [NSRC-1:0] m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

    function automatic logic code_valid(input logic [1:0] c);
        return c < 2'(NSRC);
    endfunction

endpackage

// File: rtl/clksw_mon.sv
// Edge-count monitor: the external clock drives a toggle flop, which is
// resynchronized into the reference domain and counted per window.
module clksw_mon #(
    parameter int WIN       = 64,
    parameter int MIN_EDGES = 4
) (
    input  logic clk_ref,
    input  logic clk_xt,
    input  logic rst,
    input  logic mon_en,
    output logic trip
);
    localparam int WW = $clog2(WIN);
    localparam int EW = $clog2(MIN_EDGES + 1);

    logic          tgl;
    logic [2:0]    tsync;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] ecnt;
    logic          tog_seen;

    always_ff @(posedge clk_xt) begin
        if (rst) tgl <= 1'b0;
        else     tgl <= ~tgl;
    end

    always_ff @(posedge clk_ref) begin
        if (rst) tsync <= '0;
        else     tsync <= {tsync[1:0], tgl};
    end

    assign tog_seen = tsync[2] ^ tsync[1];

    always_ff @(posedge clk_ref) begin
        if (rst || !mon_en) begin
            win_cnt <= '0;
            ecnt    <= '0;
            trip    <= 1'b0;
        end else begin
            trip <= 1'b0;
            if (win_cnt == WW'(WIN - 1)) begin
                win_cnt <= '0;
                ecnt    <= '0;
                trip    <= (ecnt < EW'(MIN_EDGES));
            end else begin
                win_cnt <= win_cnt + 1'b1;
                if (tog_seen && ecnt < EW'(MIN_EDGES))
                    ecnt <= ecnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clksw_gate.sv
// Per-source enable handshake: a request is taken on the source's rising
// edge, the enable moves on its falling edge, and a source may only request
// once every other enable is low. kill clears a gate whose clock is dead.
module clksw_gate
    import clksw_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] clk_vec,
    input  logic         rst,
    input  logic [N-1:0] kill,
    input  src_e         sel,
    output logic [N-1:0] en_vec,
    output logic         clk_out
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic [N-1:0] others;
        logic         req;
        logic         s1;
        logic         en_q;

        always_comb begin
            others    = en_vec;
            others[i] = 1'b0;
        end

        assign req = (int'(sel) == i) && (others == '0);

        always_ff @(posedge clk_vec[i] or posedge kill[i]) begin
            if (kill[i])  s1 <= 1'b0;
            else if (rst) s1 <= 1'b0;
            else          s1 <= req;
        end

        always_ff @(negedge clk_vec[i] or posedge kill[i]) begin
            if (kill[i])  en_q <= 1'b0;
            else if (rst) en_q <= 1'b0;
            else          en_q <= s1;
        end

        assign en_vec[i] = en_q;
    end

    assign clk_out = |(clk_vec & en_vec);
endmodule

// File: rtl/clksw_top.sv
module clksw_top
    import clksw_pkg::*;
#(
    parameter int WIN       = 64,
    parameter int MIN_EDGES = 4
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       clk_multi,
    input  logic       clk_rc16,
    input  logic       clk_xtal,
    input  logic       wake_standby,
    input  logic       wake_stop,
    input  logic       stop_wake_rc16,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    input  logic       mon_en,
    input  logic       fail_clr,
    output logic       clk_sys,
    output logic [1:0] active_src,
    output logic       fail_flag,
    output logic       nmi,
    output logic       timer_break
);
    src_e            sel_q;
    src_e            act_q;
    logic            flag_q;
    logic            nmi_q;
    logic            trip;
    logic [NSRC-1:0] gate_en;
    logic [NSRC-1:0] en_s1;
    logic [NSRC-1:0] en_s2;
    logic [NSRC-1:0] kill;
    logic            wr_ok;

    clksw_mon #(.WIN(WIN), .MIN_EDGES(MIN_EDGES)) i_mon (
        .clk_ref (clk_ref),
        .clk_xt  (clk_xtal),
        .rst     (rst),
        .mon_en  (mon_en),
        .trip    (trip)
    );

    assign kill = {flag_q, 2'b00};

    clksw_gate #(.N(NSRC)) i_gate (
        .clk_vec (NSRC'({clk_xtal, clk_rc16, clk_multi})),
        .rst     (rst),
        .kill    (kill),
        .sel     (sel_q),
        .en_vec  (gate_en),
        .clk_out (clk_sys)
    );

    assign wr_ok = sel_we && code_valid(sel_wdata)
                && !(src_e'(sel_wdata) == SRC_XTAL && flag_q);

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            sel_q  <= SRC_MULTI;
            flag_q <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            nmi_q <= trip && !flag_q;
            if (trip)          flag_q <= 1'b1;
            else if (fail_clr) flag_q <= 1'b0;

            if (trip)              sel_q <= SRC_RC16;
            else if (wake_standby) sel_q <= SRC_RC16;
            else if (wake_stop)    sel_q <= stop_wake_rc16 ? SRC_RC16 : SRC_MULTI;
            else if (wr_ok)        sel_q <= src_e'(sel_wdata);
        end
    end

    // status: report a source only once its gate alone is seen enabled
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            en_s1 <= '0;
            en_s2 <= '0;
            act_q <= SRC_MULTI;
        end else begin
            en_s1 <= gate_en;
            en_s2 <= en_s1;
            if (en_s2 == src_mask(sel_q)) act_q <= sel_q;
        end
    end

    assign active_src  = act_q;
    assign fail_flag   = flag_q;
    assign nmi         = nmi_q;
    assign timer_break = flag_q;
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk (
    input logic       clk_ref,
    input logic       rst,
    input logic [1:0] sel_q,
    input logic [2:0] en_vec,
    input logic [1:0] active_src,
    input logic       fail_flag,
    input logic       nmi
);
    assert_reset_state_R1: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(rst) |-> (active_src == 2'd0 && !fail_flag));

    assert_status_after_switch_R5: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(active_src) |-> active_src == $past(sel_q));

    assert_single_gate_R6: assert property (@(posedge clk_ref) disable iff (rst)
        $onehot0(en_vec));

    assert_nmi_on_flag_R8: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(fail_flag) |-> nmi);

    assert_nmi_one_cycle_R8: assert property (@(posedge clk_ref) disable iff (rst)
        nmi |=> !nmi);

    assert_no_xtal_while_failed_R9: assert property (@(posedge clk_ref) disable iff (rst)
        fail_flag |-> sel_q != 2'd2);
endmodule

bind clksw_top clksw_chk i_chk (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .sel_q      (sel_q),
    .en_vec     (gate_en),
    .active_src (active_src),
    .fail_flag  (fail_flag),
    .nmi        (nmi)
);

// File: tb/test_clksw_top.sv
`timescale 1ns/1ps
module test_clksw_top;
    logic clk_ref = 0, rst = 1;
    logic clk_multi = 0, clk_rc16 = 0, clk_xtal = 0;
    logic xtal_run = 1;
    logic wake_standby = 0, wake_stop = 0, stop_wake_rc16 = 0;
    logic sel_we = 0, mon_en = 0, fail_clr = 0;
    logic [1:0] sel_wdata = 0;
    logic clk_sys, fail_flag, nmi, timer_break;
    logic [1:0] active_src;

    int n_chk = 0, n_fail = 0;
    int sys_edges = 0;
    bit armed = 0;
    realtime last_t = 0, min_w = 1.0e9;

    clksw_top i_clksw_top (
        .clk_ref, .rst, .clk_multi, .clk_rc16, .clk_xtal,
        .wake_standby, .wake_stop, .stop_wake_rc16,
        .sel_we, .sel_wdata, .mon_en, .fail_clr,
        .clk_sys, .active_src, .fail_flag, .nmi, .timer_break
    );

    always #5 clk_ref = ~clk_ref;
    always #7 clk_multi = ~clk_multi;
    always #11 clk_rc16 = ~clk_rc16;
    always #13 if (xtal_run || clk_xtal) clk_xtal = ~clk_xtal;

    always @(posedge clk_sys) sys_edges++;
    always @(clk_sys) begin
        if (armed && last_t > 0 && ($realtime - last_t) < min_w)
            min_w = $realtime - last_t;
        last_t = $realtime;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_range(string tag, int act, int lo, int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // clk_sys rising edges in 1000 ns
    task automatic rate(string tag, int exp);
        int c0;
        c0 = sys_edges;
        cyc(100);
        chk_range(tag, sys_edges - c0, exp - 2, exp + 2);
    endtask

    task automatic wait_src(string tag, int exp);
        for (int k = 0; k < 200 && active_src != 2'(exp); k++) cyc(1);
        chk(tag, int'(active_src), exp);
    endtask

    task automatic sw_write(int code);
        sel_we = 1; sel_wdata = 2'(code);
        cyc(1);
        sel_we = 0;
    endtask

    task automatic t_reset;
        cyc(1);
        chk("R1 active after reset", active_src, 0);
        chk("R1 flag after reset", fail_flag, 0);
        chk("R1 nmi after reset", nmi, 0);
        chk("R1 break after reset", timer_break, 0);
        cyc(20);
        rate("R1 multi rate", 71);
    endtask

    task automatic t_software;
        sw_write(1);
        chk("R5 status lags write", active_src, 0);
        wait_src("R4 select rc16", 1);
        rate("R4 rc16 rate", 45);
        sw_write(2);
        wait_src("R4 select xtal", 2);
        rate("R4 xtal rate", 38);
        sw_write(3);
        cyc(60);
        chk("R4 code 3 ignored", active_src, 2);
        rate("R4 xtal kept after code 3", 38);
    endtask

    task automatic t_wake;
        wake_standby = 1; cyc(1); wake_standby = 0;
        wait_src("R2 standby exit rc16", 1);
        stop_wake_rc16 = 0; wake_stop = 1; cyc(1); wake_stop = 0;
        wait_src("R3 stop wake multi", 0);
        rate("R3 multi rate", 71);
        stop_wake_rc16 = 1; wake_stop = 1; cyc(1); wake_stop = 0;
        wait_src("R3 stop wake rc16", 1);
    endtask

    task automatic t_failure;
        int nmi_cnt = 0;
        sw_write(2);
        wait_src("R4 xtal before monitor", 2);
        mon_en = 1;
        cyc(300);
        chk("R7 no trip with running xtal", fail_flag, 0);
        xtal_run = 0;
        for (int k = 0; k < 400; k++) begin
            cyc(1);
            if (nmi) nmi_cnt++;
        end
        chk("R7 flag after xtal stop", fail_flag, 1);
        chk("R8 single nmi pulse", nmi_cnt, 1);
        chk("R8 break high", timer_break, 1);
        chk("R8 forced to rc16", active_src, 1);
        rate("R8 rc16 rate after failure", 45);
        sw_write(2);
        cyc(60);
        chk("R9 xtal write refused", active_src, 1);
        chk("R9 flag still set", fail_flag, 1);
        mon_en = 0;
        xtal_run = 1;
        cyc(5);
        fail_clr = 1; cyc(1); fail_clr = 0;
        chk("R9 flag cleared", fail_flag, 0);
        chk("R9 break cleared", timer_break, 0);
        sw_write(2);
        wait_src("R9 xtal accepted after clear", 2);
    endtask

    task automatic t_monitor_off;
        sw_write(0);
        wait_src("R4 back to multi", 0);
        xtal_run = 0;
        cyc(300);
        chk("R7 disabled monitor no trip", fail_flag, 0);
        chk("R7 disabled monitor active", active_src, 0);
    endtask

    initial begin
        cyc(10);
        rst = 0;
        cyc(3);
        armed = 1;
        t_reset;
        t_software;
        t_wake;
        t_failure;
        t_monitor_off;
        n_chk++;
        if (min_w < 6.9) begin
            n_fail++;
            $display("FAIL R6 runt phase: actual %0.2f ns expected >= 7.00 ns", min_w);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule